// File: doc/BRIEF.md
# Synchronous Burst Memory with Same-Cycle Read Data

This block is a clocked, single-port word memory. It has a combinational ("flow-through") read path: the word at the registered address appears on the read port during the same clock cycle that address is registered. No output register stage sits in between.

An access begins on a rising clock edge when one of two active-low address strobes is low. The external address is then captured as the start of a four-word burst. After that, a two-bit offset counter moves through the burst in linear order on every edge where the active-low advance input is low, and holds while it is high. Only the two low address bits change, and they wrap inside the aligned four-word block.

The block is selected only by the right pattern on three chip enables:
- `sel_n` low,
- `sel2_n` low,
- `sel3` high.

Any other pattern on a start edge is a deselect. High impedance is modelled as `rd_valid` low with `rd_data` forced to zero.

Writes use either a global write or a byte-write enable that qualifies two 9-bit lane enables. They land at the address that the same edge establishes.

The control state machine has four states:
- `ST_IDLE`: after reset, until the first start.
- `ST_READ`: a selected cycle with no write.
- `ST_WRITE`: the last edge wrote.
- `ST_DESEL`: the last start was deselected.

Its transitions are:
- Selected start (any state): goes to `ST_WRITE` if the edge writes, otherwise to `ST_READ`.
- Deselected start (any state): goes to `ST_DESEL`.
- Edge with no start, from `ST_READ` or `ST_WRITE`: goes to `ST_WRITE` when a write is requested, otherwise to `ST_READ`. The advance input decides whether the offset steps.
- Edge with no start, from `ST_IDLE` or `ST_DESEL`: the state holds.

Top module: `fsb_sram`

## Requirements
- R1: On a rising edge with a start and a valid selection, the external address is captured as the burst start. In the cycle that follows, if `oe_n` is low and no write happened on that edge, `rd_valid` is 1 and `rd_data` holds the word at that address, with no extra cycle of latency.
- R2: Inside a burst, an edge with no start and `adv_n` low moves to the next burst address. An edge with `adv_n` high presents the same address again.
- R3: The burst order is linear: low two bits `start + k` modulo 4, for k = 0 to 3. The fifth word wraps back to the start address, and the upper address bits never change during a burst.
- R4: The selection pattern is `sel_n`=0, `sel2_n`=0 and `sel3`=1. Any other pattern on a start edge is a deselect: `rd_valid` is 0 and `rd_data` is 0 until the next selected start. Write inputs without a start are ignored while deselected.
- R5: `oe_n` high forces `rd_valid` to 0 and `rd_data` to 0, combinationally and within the same cycle.
- R6: A start is a low `ads_pri_n` while `sel_n` is low, or a low `ads_sec_n`. `ads_pri_n` is ignored while `sel_n` is high. When `ads_pri_n` starts a cycle, the write inputs on that edge are ignored and the cycle is a read, even if `ads_sec_n` is also low.
- R7: A write edge has `gw_n`=0, which writes both lanes, or `bwe_n`=0 with at least one `lane_we_n` bit low, which writes the lanes whose bit is low. Lane 0 is bits 8:0 and lane 1 is bits 17:9. Data is written at the address established by that edge, and `rd_valid` is 0 in the cycle after a write edge.
- R8: After reset the state is `ST_IDLE` and `rd_valid` is 0. Write or advance inputs without a start are ignored until the first start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | External word address |
| ads_pri_n | input | 1 | Primary address strobe, active low, gated by `sel_n` |
| ads_sec_n | input | 1 | Secondary address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_n | input | 1 | Primary chip enable, active low |
| sel2_n | input | 1 | Second chip enable, active low |
| sel3 | input | 1 | Third chip enable, active high |
| oe_n | input | 1 | Output enable, active low |
| gw_n | input | 1 | Global write, all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | 2 | Per-lane write enables, active low |
| wr_data | input | 18 | Write data |
| rd_data | output | 18 | Read data, zero when not valid |
| rd_valid | output | 1 | Read data driven (not high impedance) |

## Verification
Each edge's effects (address load or step, state change, array write) become visible just after that rising edge. Read data and `rd_valid` are combinational from that registered state and `oe_n`.

The bench drives all inputs at the falling edge and updates its reference model at the rising edge. It compares `rd_valid` and `rd_data` one nanosecond later, on every clock.

For the same-cycle rule on `oe_n`, the bench also toggles `oe_n` between edges and compares again before the next rising edge. Words the model has never fully written are checked for validity only, not data.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DESEL = 2'd3
    } fsb_state_e;
endpackage

// File: rtl/fsb_burst_ctr.sv
module fsb_burst_ctr #(
    parameter int AW    = 8,
    parameter int BURST = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] load_addr,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] nxt_addr
);
    localparam int BW = $clog2(BURST);
    localparam logic [BW-1:0] ONE = BW'(1);

    logic [AW-1:0] base_q;
    logic [BW-1:0] off_q;

    assign cur_addr = {base_q[AW-1:BW], base_q[BW-1:0] + off_q};

    always_comb begin
        if (load)
            nxt_addr = load_addr;
        else if (step)
            nxt_addr = {base_q[AW-1:BW], base_q[BW-1:0] + off_q + ONE};
        else
            nxt_addr = cur_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            off_q  <= '0;
        end else if (load) begin
            base_q <= load_addr;
            off_q  <= '0;
        end else if (step) begin
            off_q  <= off_q + ONE;
        end
    end

    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cur_addr == $past(load_addr)); // R1
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(cur_addr)); // R2
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> cur_addr[BW-1:0] == BW'($past(cur_addr[BW-1:0]) + ONE)); // R3
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> cur_addr[AW-1:BW] == $past(cur_addr[AW-1:BW])); // R3
endmodule

// File: rtl/fsb_ctrl.sv
module fsb_ctrl
    import fsb_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ads_pri_n,
    input  logic             ads_sec_n,
    input  logic             adv_n,
    input  logic             sel_n,
    input  logic             sel2_n,
    input  logic             sel3,
    input  logic             oe_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_we_n,
    output logic             load,
    output logic             step,
    output logic             wr_en,
    output logic [LANES-1:0] wr_mask,
    output logic             rd_valid
);
    fsb_state_e state_q, state_d;

    logic pri_start, start, selected, wr_req;

    assign pri_start = !ads_pri_n && !sel_n;
    assign start     = pri_start || !ads_sec_n;
    assign selected  = !sel_n && !sel2_n && sel3;
    assign wr_req    = !gw_n || (!bwe_n && !(&lane_we_n));

    always_comb begin
        if (!gw_n)
            wr_mask = '1;
        else if (!bwe_n)
            wr_mask = ~lane_we_n;
        else
            wr_mask = '0;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        step    = 1'b0;
        wr_en   = 1'b0;
        if (start) begin
            if (selected) begin
                load    = 1'b1;
                wr_en   = wr_req && !pri_start;
                state_d = (wr_req && !pri_start) ? ST_WRITE : ST_READ;
            end else begin
                state_d = ST_DESEL;
            end
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DESEL: state_d = state_q;
                ST_READ, ST_WRITE: begin
                    step    = !adv_n;
                    wr_en   = wr_req;
                    state_d = wr_req ? ST_WRITE : ST_READ;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        rd_valid = (state_q == ST_READ) && !oe_n;
    end

    AST_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !selected) |=> !rd_valid); // R4
    AST_PRI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (ads_sec_n && sel_n) |-> !load); // R6
    AST_PRI_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_pri_n && !sel_n) |-> !wr_en); // R6
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !rd_valid); // R7
    AST_IDLE_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> state_q == ST_IDLE); // R8
endmodule

// File: rtl/fsb_array.sv
module fsb_array #(
    parameter int DEPTH  = 256,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [LANES-1:0]          mask,
    input  logic [$clog2(DEPTH)-1:0]  waddr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic [$clog2(DEPTH)-1:0]  raddr,
    output logic [LANES*LANE_W-1:0]   rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && mask[g])
                lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_mem[raddr];
    end
endmodule

// File: rtl/fsb_sram.sv
module fsb_sram #(
    parameter int DEPTH  = 256,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    parameter int BURST  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(DEPTH)-1:0]    addr,
    input  logic                        ads_pri_n,
    input  logic                        ads_sec_n,
    input  logic                        adv_n,
    input  logic                        sel_n,
    input  logic                        sel2_n,
    input  logic                        sel3,
    input  logic                        oe_n,
    input  logic                        gw_n,
    input  logic                        bwe_n,
    input  logic [LANES-1:0]            lane_we_n,
    input  logic [LANES*LANE_W-1:0]     wr_data,
    output logic [LANES*LANE_W-1:0]     rd_data,
    output logic                        rd_valid
);
    localparam int AW = $clog2(DEPTH);
    localparam int DW = LANES * LANE_W;

    logic             load, step, wr_en;
    logic [LANES-1:0] wr_mask;
    logic [AW-1:0]    cur_addr, nxt_addr;
    logic [DW-1:0]    arr_q;

    fsb_ctrl #(.LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ads_pri_n(ads_pri_n), .ads_sec_n(ads_sec_n), .adv_n(adv_n),
        .sel_n(sel_n), .sel2_n(sel2_n), .sel3(sel3), .oe_n(oe_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n),
        .load(load), .step(step), .wr_en(wr_en), .wr_mask(wr_mask),
        .rd_valid(rd_valid)
    );

    fsb_burst_ctr #(.AW(AW), .BURST(BURST)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .load_addr(addr), .cur_addr(cur_addr), .nxt_addr(nxt_addr)
    );

    fsb_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk(clk), .we(wr_en), .mask(wr_mask), .waddr(nxt_addr),
        .wdata(wr_data), .raddr(cur_addr), .rdata(arr_q)
    );

    assign rd_data = rd_valid ? arr_q : '0;

    AST_OE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (rd_data == '0 && !rd_valid)); // R5
    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == '0); // R4
endmodule

// File: tb/fsb_sram_bench.sv
module fsb_sram_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        ads_pri_n = 1'b1, ads_sec_n = 1'b1, adv_n = 1'b1;
    logic        sel_n = 1'b0, sel2_n = 1'b0, sel3 = 1'b1, oe_n = 1'b0;
    logic        gw_n = 1'b1, bwe_n = 1'b1;
    logic [1:0]  lane_we_n = 2'b11;
    logic [17:0] wr_data = '0;
    logic [17:0] rd_data;
    logic        rd_valid;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model: 0 idle, 1 read, 2 write, 3 deselected
    logic [17:0] rm [256];
    bit          rk [256];
    int          m_st = 0;
    int          m_base = 0;
    int          m_off = 0;

    always #4 clk = ~clk;

    fsb_sram u_fsb_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .ads_pri_n(ads_pri_n), .ads_sec_n(ads_sec_n), .adv_n(adv_n),
        .sel_n(sel_n), .sel2_n(sel2_n), .sel3(sel3), .oe_n(oe_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic int m_addr();
        return (m_base & ~3) | ((m_base + m_off) & 3);
    endfunction

    task automatic m_write(input int a);
        logic [1:0] mk;
        if (!gw_n) mk = 2'b11;
        else if (!bwe_n) mk = ~lane_we_n;
        else mk = 2'b00;
        if (mk[0]) rm[a][8:0]  = wr_data[8:0];
        if (mk[1]) rm[a][17:9] = wr_data[17:9];
        if (mk == 2'b11) rk[a] = 1'b1;
    endtask

    task automatic m_edge();
        bit pstart, start, sel, wreq;
        pstart = !ads_pri_n && !sel_n;
        start  = pstart || !ads_sec_n;
        sel    = !sel_n && !sel2_n && sel3;
        wreq   = !gw_n || (!bwe_n && lane_we_n != 2'b11);
        if (start) begin
            if (sel) begin
                m_base = int'(addr);
                m_off  = 0;
                if (!pstart && wreq) begin
                    m_write(m_addr());
                    m_st = 2;
                end else m_st = 1;
            end else m_st = 3;
        end else if (m_st == 1 || m_st == 2) begin
            if (!adv_n) m_off = (m_off + 1) % 4;
            if (wreq) begin
                m_write(m_addr());
                m_st = 2;
            end else m_st = 1;
        end
    endtask

    task automatic compare(input string tag);
        bit          ev;
        logic [17:0] ed;
        int          a;
        a  = m_addr();
        ev = (m_st == 1) && !oe_n;
        ed = ev ? rm[a] : 18'd0;
        n_cmp++;
        if (rd_valid !== ev || ((!ev || rk[a]) && rd_data !== ed)) begin
            n_bad++;
            $display("FAIL %s: rd_valid=%0b rd_data=%05h, expected rd_valid=%0b rd_data=%05h",
                     tag, rd_valid, rd_data, ev, ed);
        end
    endtask

    task automatic cyc(input logic p_n, input logic s_n, input logic av_n,
                       input logic e1, input logic e2, input logic e3,
                       input logic o_n, input logic g_n, input logic b_n,
                       input logic [1:0] lw, input logic [7:0] a,
                       input logic [17:0] d, input string tag);
        ads_pri_n = p_n; ads_sec_n = s_n; adv_n = av_n;
        sel_n = e1; sel2_n = e2; sel3 = e3; oe_n = o_n;
        gw_n = g_n; bwe_n = b_n; lane_we_n = lw; addr = a; wr_data = d;
        @(posedge clk);
        m_edge();
        #1;
        compare(tag);
        @(negedge clk);
    endtask

    task automatic rd_start(input logic [7:0] a, input string tag);
        cyc(1, 0, 1, 0, 0, 1, 0, 1, 1, 2'b11, a, 18'd0, tag);
    endtask

    task automatic wr_start(input logic [7:0] a, input logic [17:0] d, input string tag);
        cyc(1, 0, 1, 0, 0, 1, 0, 0, 1, 2'b11, a, d, tag);
    endtask

    task automatic advance(input logic av_n, input string tag);
        cyc(1, 1, av_n, 0, 0, 1, 0, 1, 1, 2'b11, 8'd0, 18'd0, tag);
    endtask

    task automatic oe_flip(input string tag);
        oe_n = ~oe_n;
        #1;
        compare(tag);
        oe_n = ~oe_n;
        #1;
        compare(tag);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin rm[i] = '0; rk[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare("R8 reset");
        @(negedge clk);
        // R8: write and advance without a start are ignored in idle
        cyc(1, 1, 0, 0, 0, 1, 0, 0, 1, 2'b11, 8'd5, 18'h3ffff, "R8");
        advance(0, "R8");
        // R7: fill words 0..15 with full-word writes
        for (int i = 0; i < 16; i++)
            wr_start(8'(i), 18'(i * 4111 + 7), "R7");
        // R7: burst write starting at 16 with advance
        wr_start(8'd16, 18'h12345, "R7");
        for (int i = 1; i < 4; i++)
            cyc(1, 1, 0, 0, 0, 1, 0, 0, 1, 2'b11, 8'd0, 18'(18'h20000 + i), "R7");
        // R1 R2 R3: burst read from 4, then wrap
        rd_start(8'd4, "R1");
        advance(0, "R2");
        advance(0, "R2");
        advance(0, "R3");
        advance(0, "R3");
        // R3: unaligned start wraps inside block
        rd_start(8'd6, "R3");
        advance(0, "R3");
        advance(0, "R3");
        advance(0, "R3");
        advance(1, "R2");
        advance(1, "R2");
        rd_start(8'd17, "R3");
        for (int i = 0; i < 4; i++) advance(0, "R3");
        // R4: each bad enable pattern deselects
        cyc(1, 0, 1, 0, 1, 1, 0, 1, 1, 2'b11, 8'd2, 18'd0, "R4");
        advance(0, "R4");
        cyc(1, 1, 1, 0, 0, 1, 0, 0, 1, 2'b11, 8'd0, 18'h3ffff, "R4");
        rd_start(8'd2, "R4");
        cyc(1, 0, 1, 0, 0, 0, 0, 1, 1, 2'b11, 8'd2, 18'd0, "R4");
        cyc(1, 0, 1, 1, 0, 1, 0, 1, 1, 2'b11, 8'd2, 18'd0, "R4");
        rd_start(8'd1, "R4");
        // R6: primary strobe gated by sel_n, and read-only when it starts
        cyc(0, 1, 1, 1, 0, 1, 0, 1, 1, 2'b11, 8'd9, 18'd0, "R6");
        cyc(0, 0, 1, 0, 0, 1, 0, 0, 1, 2'b11, 8'd3, 18'h0abcd, "R6");
        rd_start(8'd3, "R6");
        cyc(0, 1, 1, 0, 0, 1, 0, 1, 1, 2'b11, 8'd8, 18'd0, "R6");
        // R7: lane writes
        rd_start(8'd10, "R7");
        cyc(1, 1, 1, 0, 0, 1, 0, 1, 0, 2'b10, 8'd0, 18'h15a5a, "R7");
        advance(1, "R7");
        cyc(1, 1, 0, 0, 0, 1, 0, 1, 0, 2'b01, 8'd0, 18'h2c3c3, "R7");
        advance(1, "R7");
        cyc(1, 1, 1, 0, 0, 1, 0, 1, 0, 2'b11, 8'd0, 18'h3ffff, "R7");
        // R5: output enable
        cyc(1, 0, 1, 0, 0, 1, 1, 1, 1, 2'b11, 8'd12, 18'd0, "R5");
        oe_flip("R5");
        advance(0, "R5");
        oe_flip("R5");
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[0] | r[1], r[2] | r[3], r[4], r[5] & r[6], r[7] & r[8],
                r[9] | r[10], r[11] & r[12], r[13] | r[14], r[15], r[17:16],
                8'(r[23:18] % 32), 18'($urandom), "R1 mix");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule